// File: doc/BRIEF.md
# Maskable BCD Alarm Comparator

This block holds a 32-bit alarm word and checks it against the running BCD calendar once for each calendar second. The calendar is supplied on a time word and a date word. Each of the four alarm fields has its own don't-care bit: seconds, minutes, hours with PM, and day. A selector bit chooses whether the day field is compared with the day of the month or with the weekday. A match sets a sticky alarm flag. The interrupt line follows that flag only while the interrupt enable is set. Month and year never take part in the comparison, and the calendar itself is counted elsewhere.

Software reaches the block through a small write-only register port. Address 0 is control, with alarm enable at bit 8 and interrupt enable at bit 12. Address 1 is the alarm word. Address 2 clears the flag when bit 0 is written as 0. When `CLEAR_ON_ONE` is 1, address 3 clears the flag instead, on a write with bit 0 set. Alarm word writes are honoured only while the write-allowed status is high.

The write-allowed status is produced by a three-state machine. ARMED means the alarm is enabled and the status is low. DRAIN means the alarm was just disabled, and a counter is running. OPEN means the status is high.
- ARMED goes to DRAIN when the enable clears.
- DRAIN goes to OPEN after `WAIT_CYCLES` cycles.
- DRAIN or OPEN goes back to ARMED when the enable is set.
- Reset enters DRAIN.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: During reset, and on the first cycle after it, alarm_flag, alarm_irq and wr_allowed are all 0.
- R2: Writing control (address 0) with bit 8 set drives wr_allowed low by the second clock edge after the write.
- R3: After the enable is cleared, wr_allowed stays low on the first WAIT_CYCLES edges after the FSM leaves ARMED and is high from the next edge on.
- R4: A write to the alarm word (address 1) while wr_allowed is 0 is ignored, and the previously stored word keeps governing matches.
- R5: The alarm word holds seconds in bits 6:0 (mask bit 7), minutes in bits 14:8 (mask bit 15) and hours with PM in bits 22:16 (mask bit 23). These are compared with time_word bits 6:0, 14:8 and 22:16. A set mask bit removes its field from the comparison.
- R6: Alarm bits 29:24 compare with date_word bits 5:0 (day of month) when bit 30 is 0. When bit 30 is 1, alarm bits 27:24 compare with date_word bits 15:13 (weekday) zero-extended. Bit 31 masks the day field.
- R7: A match is evaluated only on a cycle with sec_tick high while the alarm is enabled. Without a tick, or with the enable clear, the flag is not set.
- R8: alarm_flag is set on the edge after a matching tick and stays set until cleared. With CLEAR_ON_ONE=0 it is cleared by writing address 2 with bit 0 = 0, and a write with bit 0 = 1 has no effect. A set in the same cycle wins over a clear.
- R9: alarm_irq is high exactly when alarm_flag is high and control bit 12 is set.
- R10: A match held across cycles does not set the flag again after a clear until the next sec_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe on each calendar second update |
| time_word | input | 23 | BCD seconds 6:0, minutes 14:8, hours 21:16, PM 22 |
| date_word | input | 16 | BCD day of month 5:0, weekday 15:13 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |
| wr_allowed | output | 1 | Alarm word may be written |

## Verification
The assertions assume that time_word and date_word are stable in any cycle where sec_tick is high. They also assume sec_tick is a single-cycle strobe, and that register writes are single-cycle pulses with a defined address. The stimulus meets these assumptions: every input is driven on the falling clock edge, sec_tick is pulsed for exactly one cycle after the calendar words are set, and each register write lasts one cycle. The random alarm words carry random masks and selector bits. Half the calendar values are derived from the alarm word so that matches occur often.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
    localparam int REG_AW     = 2;
    localparam logic [REG_AW-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_ALARM = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_FLAG  = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_CLR   = 2'd3;
    localparam int CTRL_EN_BIT = 8;
    localparam int CTRL_IE_BIT = 12;

    typedef enum logic [1:0] {
        WG_ARMED = 2'd0,
        WG_DRAIN = 2'd1,
        WG_OPEN  = 2'd2
    } wg_state_e;
endpackage

// File: rtl/bcd_alarm_wrgate.sv
module bcd_alarm_wrgate
    import bcd_alarm_pkg::*;
#(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic wr_ok
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(WAIT_CYCLES - 1);

    wg_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WG_DRAIN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == WG_DRAIN) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WG_ARMED: if (!en) state_d = WG_DRAIN;
            WG_DRAIN: begin
                if (en)                    state_d = WG_ARMED;
                else if (cnt_q == CNT_LAST) state_d = WG_OPEN;
            end
            WG_OPEN:  if (en) state_d = WG_ARMED;
            default:  state_d = WG_DRAIN;
        endcase
    end

    always_comb begin
        wr_ok = (state_q == WG_OPEN);
    end

    a_r2_en_closes_gate: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> !wr_ok);
    a_r3_drain_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WG_ARMED && !en) |=> !wr_ok);
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match #(
    parameter int NUM_TIME_FIELDS = 3,
    parameter int FIELD_STRIDE    = 8
) (
    input  logic [31:0] alarm_word,
    input  logic [22:0] time_word,
    input  logic [15:0] date_word,
    output logic        hit
);
    localparam int VAL_W = FIELD_STRIDE - 1;

    logic [NUM_TIME_FIELDS-1:0] field_hit;

    for (genvar g = 0; g < NUM_TIME_FIELDS; g++) begin : g_field
        localparam int LO = g * FIELD_STRIDE;
        assign field_hit[g] = alarm_word[LO+VAL_W] ||
            (alarm_word[LO+VAL_W-1:LO] == time_word[LO+VAL_W-1:LO]);
    end

    logic day_hit;
    always_comb begin
        if (alarm_word[31])
            day_hit = 1'b1;
        else if (alarm_word[30])
            day_hit = (alarm_word[27:24] == {1'b0, date_word[15:13]});
        else
            day_hit = (alarm_word[29:24] == date_word[5:0]);
    end

    assign hit = (&field_hit) && day_hit;
endmodule

// File: rtl/bcd_alarm_flag.sv
module bcd_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_evt) flag <= 1'b0;
    end

    a_r8_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_evt) |=> flag);
    a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set_evt) |=> !flag);
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
    import bcd_alarm_pkg::*;
#(
    parameter int WAIT_CYCLES  = 2,
    parameter bit CLEAR_ON_ONE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_tick,
    input  logic [22:0] time_word,
    input  logic [15:0] date_word,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        alarm_flag,
    output logic        alarm_irq,
    output logic        wr_allowed
);
    logic        en_q, ie_q;
    logic [31:0] alarm_q;
    logic        hit, set_evt, clr_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            ie_q    <= 1'b0;
            alarm_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_CTRL) begin
                en_q <= reg_wdata[CTRL_EN_BIT];
                ie_q <= reg_wdata[CTRL_IE_BIT];
            end
            if (reg_addr == ADDR_ALARM && wr_allowed)
                alarm_q <= reg_wdata;
        end
    end

    bcd_alarm_wrgate #(.WAIT_CYCLES(WAIT_CYCLES)) u_wrgate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .wr_ok (wr_allowed)
    );

    bcd_alarm_match u_match (
        .alarm_word (alarm_q),
        .time_word  (time_word),
        .date_word  (date_word),
        .hit        (hit)
    );

    assign set_evt = sec_tick && en_q && hit;

    if (CLEAR_ON_ONE) begin : g_clr_one
        assign clr_evt = reg_we && (reg_addr == ADDR_CLR) && reg_wdata[0];
    end else begin : g_clr_zero
        assign clr_evt = reg_we && (reg_addr == ADDR_FLAG) && !reg_wdata[0];
    end

    bcd_alarm_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .clr_evt (clr_evt),
        .flag    (alarm_flag)
    );

    assign alarm_irq = alarm_flag && ie_q;

    a_r4_word_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allowed |=> $stable(alarm_q));
    a_r9_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> ie_q);
    a_r7_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(sec_tick && en_q));
endmodule

// File: tb/bcd_alarm_cmp_tb_top.sv
module bcd_alarm_cmp_tb_top;
    localparam int WAIT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [22:0] time_word = '0;
    logic [15:0] date_word = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        alarm_flag, alarm_irq, wr_allowed;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bcd_alarm_cmp #(.WAIT_CYCLES(WAIT), .CLEAR_ON_ONE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .time_word(time_word), .date_word(date_word),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq), .wr_allowed(wr_allowed)
    );

    function automatic bit ref_match(input logic [31:0] a, input logic [22:0] t,
                                     input logic [15:0] d);
        bit ok = 1'b1;
        if (!a[7]  && a[6:0]   != t[6:0])   ok = 1'b0;
        if (!a[15] && a[14:8]  != t[14:8])  ok = 1'b0;
        if (!a[23] && a[22:16] != t[22:16]) ok = 1'b0;
        if (!a[31]) begin
            if (a[30]) begin
                if (a[27:24] != {1'b0, d[15:13]}) ok = 1'b0;
            end else if (a[29:24] != d[5:0]) ok = 1'b0;
        end
        return ok;
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0b expected=%0b", req, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] addr, input logic [31:0] data);
        reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic wait_open();
        for (int i = 0; i < 20 && !wr_allowed; i++) @(negedge clk);
    endtask

    task automatic program_alarm(input logic [31:0] word, input bit ie);
        reg_wr(2'd0, 32'h0);
        wait_open();
        reg_wr(2'd1, word);
        reg_wr(2'd0, {19'h0, ie, 3'h0, 1'b1, 8'h0});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: got=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] aw;
        logic [22:0] tw;
        logic [15:0] dw;
        bit ie, force_hit;
        void'($urandom(32'h5eed_1234));

        repeat (3) @(negedge clk);
        check("R1 flag in reset", alarm_flag, 1'b0);
        check("R1 irq in reset", alarm_irq, 1'b0);
        check("R1 wr_allowed in reset", wr_allowed, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wr_allowed after reset", wr_allowed, 1'b0);
        check("R1 flag after reset", alarm_flag, 1'b0);

        // R2 and R3 gate timing
        wait_open();
        reg_wr(2'd0, 32'h0000_0100);
        @(negedge clk);
        check("R2 gate closed after enable", wr_allowed, 1'b0);
        reg_wr(2'd0, 32'h0);
        @(negedge clk);
        check("R3 low edge 1", wr_allowed, 1'b0);
        @(negedge clk);
        check("R3 low edge 2", wr_allowed, 1'b0);
        @(negedge clk);
        check("R3 high after wait", wr_allowed, 1'b1);

        // R5 exact match with PM hour, day of month
        program_alarm({2'b00, 6'h15, 1'b0, 7'h51, 1'b0, 7'h30, 1'b0, 7'h45}, 1'b1);
        time_word = {7'h51, 1'b0, 7'h30, 1'b0, 7'h44}; date_word = 16'h0015;
        tick();
        check("R5 seconds mismatch no flag", alarm_flag, 1'b0);
        time_word[6:0] = 7'h45;
        @(negedge clk);
        check("R7 no tick no flag", alarm_flag, 1'b0);
        tick();
        check("R5 full match sets flag", alarm_flag, 1'b1);
        check("R9 irq with ie", alarm_irq, 1'b1);

        // R8 sticky and clear semantics
        time_word[6:0] = 7'h00;
        tick();
        check("R8 flag sticky", alarm_flag, 1'b1);
        reg_wr(2'd2, 32'h1);
        check("R8 write one to flag no effect", alarm_flag, 1'b1);
        reg_wr(2'd2, 32'h0);
        check("R8 write zero clears", alarm_flag, 1'b0);
        check("R9 irq follows flag", alarm_irq, 1'b0);

        // R10 held match, then set wins over clear
        time_word[6:0] = 7'h45;
        tick();
        reg_wr(2'd2, 32'h0);
        repeat (2) @(negedge clk);
        check("R10 held match no retrigger", alarm_flag, 1'b0);
        sec_tick = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0;
        @(negedge clk);
        sec_tick = 1'b0; reg_we = 1'b0;
        check("R8 set wins over clear", alarm_flag, 1'b1);
        reg_wr(2'd2, 32'h0);

        // R4 write ignored while armed
        reg_wr(2'd1, 32'h8080_8000);
        time_word = {7'h11, 1'b0, 7'h22, 1'b0, 7'h33};
        tick();
        check("R4 locked write ignored", alarm_flag, 1'b0);
        time_word = {7'h51, 1'b0, 7'h30, 1'b0, 7'h45};
        tick();
        check("R4 old word still matches", alarm_flag, 1'b1);
        reg_wr(2'd2, 32'h0);

        // R7 disabled alarm never sets
        reg_wr(2'd0, 32'h0000_1000);
        tick();
        check("R7 disabled no flag", alarm_flag, 1'b0);

        // R6 weekday select and R9 without ie
        program_alarm({1'b0, 1'b1, 2'b00, 4'h3, 1'b1, 7'h0, 1'b1, 7'h0, 1'b1, 7'h0}, 1'b0);
        date_word = {3'd3, 7'h0, 6'h05};
        tick();
        check("R6 weekday match", alarm_flag, 1'b1);
        check("R9 no irq without ie", alarm_irq, 1'b0);
        reg_wr(2'd2, 32'h0);
        date_word = {3'd4, 7'h0, 6'h03};
        tick();
        check("R6 weekday mismatch ignores mday", alarm_flag, 1'b0);

        // random mix R5 R6 R9
        for (int n = 0; n < 40; n++) begin
            aw = $urandom;
            ie = $urandom_range(0, 1);
            force_hit = $urandom_range(0, 1);
            tw = $urandom;
            dw = $urandom;
            if (force_hit) begin
                tw[6:0] = aw[6:0]; tw[14:8] = aw[14:8]; tw[22:16] = aw[22:16];
                if (aw[30]) begin
                    aw[27] = 1'b0;
                    dw[15:13] = aw[26:24];
                end else dw[5:0] = aw[29:24];
            end
            program_alarm(aw, ie);
            time_word = tw; date_word = dw;
            tick();
            check("R5 R6 random flag", alarm_flag, ref_match(aw, tw, dw));
            check("R9 random irq", alarm_irq, ref_match(aw, tw, dw) & ie);
            reg_wr(2'd2, 32'h0);
            check("R8 random clear", alarm_flag, 1'b0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule